// File: doc/BRIEF.md
# Gated Frequency Counter

This block measures how many rising edges an external digitised signal produces during a gate window, and holds the count in a result register for readout. The window is timed from a reference tick that pulses once per period of a 75 kHz reference clock, delivered as a one-cycle strobe in the core clock domain. The core clock must be fast enough to resolve the count input, which ranges from 0.1 MHz to 20 MHz.

Software chooses one of four automatic gate lengths: 1 ms, 4 ms, 16 ms or 64 ms of reference time. It can instead pick manual mode, where a start command opens the gate and a stop command closes it. A timer source option counts reference ticks in place of the external input. This option applies when the reference is not the 75 kHz source and the block serves as a timer. The count saturates rather than wrapping, and a done flag reports a finished measurement.

Top module: `gated_freq_counter`

## Requirements
- R1: While reset is asserted and right after it is released, `result` is 0 and `done`, `overflow` and `gateOpen` are all 0.
- R2: With `manualMode`=0, the gate opens on `startCmd` and closes on the N-th `refTick` after it. N is 75 for `gateSel`=0, 300 for 1, 1200 for 2 and 4800 for 3. `done` reads 1 in the cycle after the edge that samples the closing tick, and reads 0 before that.
- R3: With `srcTimer`=0, the count is the number of rising edges of `sigIn` that occur while the gate is open. Edges that arrive while no measurement is running are not counted.
- R4: With `srcTimer`=1, the count is the number of `refTick` pulses sampled while the gate is open, and `sigIn` has no effect. In an automatic gate of length N the result is therefore exactly N.
- R5: With `manualMode`=1, `startCmd` opens the gate and `stopCmd` closes it. The result and `done`=1 are visible in the cycle after the edge that samples `stopCmd`.
- R6: `stopCmd` has no effect during an automatic gate, and no effect while idle: `result` and `done` stay as they were.
- R7: `manualMode`, `srcTimer` and `gateSel` are captured at `startCmd`. Changes to them while the gate is open do not alter the running measurement.
- R8: A `startCmd` while the gate is open restarts the measurement. It discards the count so far and restarts the window.
- R9: `done` reads 0 in the cycle after `startCmd`. `result` keeps its previous value until the next gate close.
- R10: The count stops at 2^COUNT_W-1 (20 bits by default), and `overflow` is 1 for a measurement that saw more events than that. A measurement of exactly 2^COUNT_W-1 events gives `overflow`=0.
- R11: `gateOpen` is 1 from the cycle after `startCmd` until the gate closes, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | 1 | One-cycle strobe per reference period |
| sigIn | input | 1 | Asynchronous digitised count input |
| manualMode | input | 1 | 1: gate controlled by start/stop commands |
| srcTimer | input | 1 | 1: count reference ticks instead of sigIn |
| gateSel | input | 2 | Automatic gate length select |
| startCmd | input | 1 | One-cycle command that starts a measurement |
| stopCmd | input | 1 | One-cycle command that closes a manual gate |
| result | output | COUNT_W | Latched count of the last measurement |
| done | output | 1 | Measurement finished, result valid |
| overflow | output | 1 | Last measurement saturated |
| gateOpen | output | 1 | Gate currently open |

## Verification
The latched result and `done` are due one cycle after the clock edge that samples the closing reference tick or the stop command. A rising edge on `sigIn` reaches the counter on the third clock edge after it is driven. The bench drives every input and samples every output on the falling clock edge. It tracks the exact cycle in which it issues the N-th tick, and it requires `done` and `gateOpen` to be 0 and 1 on every falling edge before that cycle and to change exactly one cycle after it. Input pulses are placed so that their synchroniser delay ends well inside the window. Manual gates close only after the last edge has had time to be counted.

// File: rtl/fgc_pkg.sv
package fgc_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_GATE = 1'b1
  } gateState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;    // start of measurement: clear counter and done
    logic cntEn;     // gate open: count events
    logic latch;     // gate closing: load result
    logic useTimer;  // event source is the reference tick
  } ctrlStrobe_t;

endpackage

// File: rtl/fgc_input_sync.sv
module fgc_input_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sigIn,
  output logic edgePulse
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] syncQ;
  logic         prevQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[TOP-1:0], sigIn};
      prevQ <= syncQ[TOP];
    end
  end

  assign edgePulse = syncQ[TOP] & ~prevQ;

  // R3
  edge_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    edgePulse |=> !edgePulse);

endmodule

// File: rtl/fgc_control.sv
module fgc_control
  import fgc_pkg::*;
#(
  parameter int BASE_TICKS = 75
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        refTick,
  input  logic        startCmd,
  input  logic        stopCmd,
  input  logic        manualMode,
  input  logic        srcTimer,
  input  logic [1:0]  gateSel,
  output ctrlStrobe_t str,
  output logic        gateOpen
);

  localparam int MAX_TICKS = BASE_TICKS * 64;
  localparam int WIN_W     = $clog2(MAX_TICKS + 1);
  localparam logic [WIN_W-1:0] LEN0 = WIN_W'(BASE_TICKS);
  localparam logic [WIN_W-1:0] LEN1 = WIN_W'(BASE_TICKS * 4);
  localparam logic [WIN_W-1:0] LEN2 = WIN_W'(BASE_TICKS * 16);
  localparam logic [WIN_W-1:0] LEN3 = WIN_W'(BASE_TICKS * 64);

  gateState_t       stateQ;
  logic [WIN_W-1:0] winCntQ;
  logic [WIN_W-1:0] limitTicks;
  logic             cfgManualQ;
  logic             cfgTimerQ;
  logic [1:0]       cfgSelQ;
  logic             inGate;
  logic             lastTick;
  logic             closeNow;

  always_comb begin
    case (cfgSelQ)
      2'd0:    limitTicks = LEN0;
      2'd1:    limitTicks = LEN1;
      2'd2:    limitTicks = LEN2;
      default: limitTicks = LEN3;
    endcase
  end

  assign inGate   = (stateQ == ST_GATE);
  assign lastTick = (winCntQ == limitTicks - 1'b1);
  assign closeNow = inGate & ~startCmd &
                    (cfgManualQ ? stopCmd : (refTick & lastTick));

  always_comb begin
    str          = '0;
    str.clrCnt   = startCmd;
    str.cntEn    = inGate & ~startCmd;
    str.latch    = closeNow;
    str.useTimer = cfgTimerQ;
  end

  assign gateOpen = inGate;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      winCntQ    <= '0;
      cfgManualQ <= 1'b0;
      cfgTimerQ  <= 1'b0;
      cfgSelQ    <= 2'd0;
    end else if (startCmd) begin
      stateQ     <= ST_GATE;
      winCntQ    <= '0;
      cfgManualQ <= manualMode;
      cfgTimerQ  <= srcTimer;
      cfgSelQ    <= gateSel;
    end else if (closeNow) begin
      stateQ  <= ST_IDLE;
      winCntQ <= '0;
    end else if (inGate && !cfgManualQ && refTick) begin
      winCntQ <= winCntQ + 1'b1;
    end
  end

  // R2
  win_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    inGate |-> (winCntQ < limitTicks));

  // R5
  start_opens_chk: assert property (@(posedge clk) disable iff (!rstN)
    startCmd |=> (stateQ == ST_GATE));

  // R6
  auto_stop_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inGate && !cfgManualQ && stopCmd && !startCmd && !refTick) |=> (stateQ == ST_GATE));

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inGate && !startCmd) |=> ($stable(cfgSelQ) && $stable(cfgManualQ) && $stable(cfgTimerQ)));

endmodule

// File: rtl/fgc_datapath.sv
module fgc_datapath
  import fgc_pkg::*;
#(
  parameter int COUNT_W = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        str,
  input  logic               refTick,
  input  logic               edgePulse,
  output logic [COUNT_W-1:0] result,
  output logic               done,
  output logic               overflow
);

  localparam logic [COUNT_W-1:0] CNT_MAX = '1;

  logic [COUNT_W-1:0] countQ;
  logic [COUNT_W-1:0] countNext;
  logic [COUNT_W-1:0] resultQ;
  logic               ovfQ;
  logic               ovfNext;
  logic               resultOvfQ;
  logic               doneQ;
  logic               srcEvent;
  logic               incEn;
  logic               atMax;

  assign srcEvent = str.useTimer ? refTick : edgePulse;
  assign incEn    = str.cntEn & srcEvent;
  assign atMax    = (countQ == CNT_MAX);

  always_comb begin
    countNext = countQ;
    ovfNext   = ovfQ;
    if (incEn) begin
      if (atMax) ovfNext   = 1'b1;
      else       countNext = countQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ     <= '0;
      ovfQ       <= 1'b0;
      resultQ    <= '0;
      resultOvfQ <= 1'b0;
      doneQ      <= 1'b0;
    end else begin
      if (str.clrCnt) begin
        countQ <= '0;
        ovfQ   <= 1'b0;
        doneQ  <= 1'b0;
      end else begin
        countQ <= countNext;
        ovfQ   <= ovfNext;
      end
      if (str.latch) begin
        resultQ    <= countNext;
        resultOvfQ <= ovfNext;
        doneQ      <= 1'b1;
      end
    end
  end

  assign result   = resultQ;
  assign done     = doneQ;
  assign overflow = resultOvfQ;

  // R5
  done_after_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.latch |=> done);

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.clrCnt |=> (!done && countQ == '0));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !str.latch |=> $stable(result));

  // R10
  saturate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (atMax && incEn && !str.clrCnt) |=> (countQ == CNT_MAX && ovfQ));

endmodule

// File: rtl/gated_freq_counter.sv
module gated_freq_counter
  import fgc_pkg::*;
#(
  parameter int COUNT_W     = 20,
  parameter int BASE_TICKS  = 75,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refTick,
  input  logic               sigIn,
  input  logic               manualMode,
  input  logic               srcTimer,
  input  logic [1:0]         gateSel,
  input  logic               startCmd,
  input  logic               stopCmd,
  output logic [COUNT_W-1:0] result,
  output logic               done,
  output logic               overflow,
  output logic               gateOpen
);

  ctrlStrobe_t str;
  logic        edgePulse;

  fgc_input_sync #(.SYNC_STAGES(SYNC_STAGES)) uSync (
    .clk       (clk),
    .rstN      (rstN),
    .sigIn     (sigIn),
    .edgePulse (edgePulse)
  );

  fgc_control #(.BASE_TICKS(BASE_TICKS)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .refTick    (refTick),
    .startCmd   (startCmd),
    .stopCmd    (stopCmd),
    .manualMode (manualMode),
    .srcTimer   (srcTimer),
    .gateSel    (gateSel),
    .str        (str),
    .gateOpen   (gateOpen)
  );

  fgc_datapath #(.COUNT_W(COUNT_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .str       (str),
    .refTick   (refTick),
    .edgePulse (edgePulse),
    .result    (result),
    .done      (done),
    .overflow  (overflow)
  );

  // R11
  gate_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gateOpen && !startCmd && !str.latch) |=> (gateOpen && !done));

endmodule

// File: tb/tb_gated_freq_counter.sv
module tb_gated_freq_counter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refTick = 1'b0;
  logic        sigIn = 1'b0;
  logic        manualMode = 1'b0;
  logic        srcTimer = 1'b0;
  logic [1:0]  gateSel = 2'd0;
  logic        startCmd = 1'b0;
  logic        stopCmd = 1'b0;
  logic [19:0] result;
  logic        done, overflow, gateOpen;
  logic [5:0]  resultN;
  logic        doneN, overflowN, gateOpenN;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  gated_freq_counter dut (
    .clk(clk), .rstN(rstN), .refTick(refTick), .sigIn(sigIn),
    .manualMode(manualMode), .srcTimer(srcTimer), .gateSel(gateSel),
    .startCmd(startCmd), .stopCmd(stopCmd),
    .result(result), .done(done), .overflow(overflow), .gateOpen(gateOpen)
  );

  gated_freq_counter #(.COUNT_W(6)) dutNarrow (
    .clk(clk), .rstN(rstN), .refTick(refTick), .sigIn(sigIn),
    .manualMode(manualMode), .srcTimer(srcTimer), .gateSel(gateSel),
    .startCmd(startCmd), .stopCmd(stopCmd),
    .result(resultN), .done(doneN), .overflow(overflowN), .gateOpen(gateOpenN)
  );

  typedef struct packed {
    logic        manual;
    logic        timer;
    logic [1:0]  sel;
    logic [15:0] amount;
    logic [19:0] expVal;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b1, 2'd0, 16'd10, 20'd75},
    '{1'b0, 1'b1, 2'd1, 16'd0,  20'd300},
    '{1'b0, 1'b1, 2'd2, 16'd0,  20'd1200},
    '{1'b0, 1'b1, 2'd3, 16'd0,  20'd4800},
    '{1'b0, 1'b0, 2'd0, 16'd20, 20'd20},
    '{1'b0, 1'b0, 2'd1, 16'd33, 20'd33},
    '{1'b1, 1'b0, 2'd0, 16'd7,  20'd7},
    '{1'b1, 1'b1, 2'd0, 16'd50, 20'd50},
    '{1'b1, 1'b0, 2'd0, 16'd0,  20'd0}
  };

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic pulseAt(input int cyc, input int pulses);
    if (cyc < 8) return 1'b0;
    return ((cyc - 8) / 6 < pulses) && ((cyc - 8) % 6 < 3);
  endfunction

  task automatic doStart(input logic man, input logic tmr, input logic [1:0] sel);
    @(negedge clk);
    manualMode = man; srcTimer = tmr; gateSel = sel;
    refTick = 1'b0; sigIn = 1'b0; startCmd = 1'b1;
    @(negedge clk);
    startCmd = 1'b0;
  endtask

  task automatic sendPulses(input int k);
    for (int c = 0; c < k * 6 + 20; c++) begin
      sigIn = pulseAt(c, k);
      @(negedge clk);
    end
    sigIn = 1'b0;
  endtask

  task automatic sendTicks(input int k);
    for (int c = 0; c < k * 4 + 8; c++) begin
      refTick = (c % 4 == 3) && (c / 4 < k);
      @(negedge clk);
    end
    refTick = 1'b0;
  endtask

  task automatic doStop();
    stopCmd = 1'b1;
    @(negedge clk);
    stopCmd = 1'b0;
  endtask

  task automatic runAuto(input logic [1:0] sel, input logic tmr, input int pulses,
                         input int expVal, input int stopAt, input bit disturb,
                         input string tag);
    int n = 75 << (2 * sel);
    int ticks = 0;
    int cyc = 0;
    bit bad = 0;
    logic [19:0] prevRes = result;
    doStart(1'b0, tmr, sel);
    check(done == 1'b0, {tag, " R9 done cleared"}, done, 0);
    check(result == prevRes, {tag, " R9 result held"}, result, prevRes);
    if (disturb) begin
      gateSel = ~sel; manualMode = 1'b1; srcTimer = ~tmr;
    end
    while (ticks < n) begin
      if (done || !gateOpen) bad = 1;
      refTick = (cyc % 4 == 3);
      sigIn = pulseAt(cyc, pulses);
      stopCmd = (stopAt != 0) && (ticks == stopAt) && (cyc % 4 == 1);
      if (refTick) ticks++;
      cyc++;
      @(negedge clk);
    end
    refTick = 1'b0; sigIn = 1'b0; stopCmd = 1'b0;
    check(!bad, {tag, " R2 R11 done low and gate open before closing tick"}, bad, 0);
    check(done == 1'b1, {tag, " R2 done one cycle after closing tick"}, done, 1);
    check(gateOpen == 1'b0, {tag, " R11 gate closed"}, gateOpen, 0);
    check(result == expVal, {tag, " R2 R3 R4 result"}, result, expVal);
    manualMode = 1'b0; srcTimer = 1'b0; gateSel = 2'd0;
  endtask

  task automatic runManual(input logic tmr, input int amount, input int expVal,
                           input string tag);
    doStart(1'b1, tmr, 2'd0);
    check(gateOpen == 1'b1, {tag, " R11 gate open"}, gateOpen, 1);
    for (int c = 0; c < amount * 6 + 20; c++) begin
      refTick = (c % 4 == 3) && (c / 4 < amount);
      sigIn = pulseAt(c, amount);
      @(negedge clk);
    end
    refTick = 1'b0; sigIn = 1'b0;
    check(done == 1'b0, {tag, " R5 done low before stop"}, done, 0);
    doStop();
    check(done == 1'b1, {tag, " R5 done after stop"}, done, 1);
    check(result == expVal, {tag, " R5 R3 R4 result"}, result, expVal);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, checks + 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check(result == 0 && !done && !overflow && !gateOpen, "R1 during reset",
          {result, done, overflow, gateOpen}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(result == 0 && !done && !overflow && !gateOpen, "R1 after reset",
          {result, done, overflow, gateOpen}, 0);

    // table of vectors
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].manual)
        runManual(VECS[i].timer, int'(VECS[i].amount), int'(VECS[i].expVal), $sformatf("vec%0d", i));
      else
        runAuto(VECS[i].sel, VECS[i].timer, int'(VECS[i].amount), int'(VECS[i].expVal),
                0, 1'b0, $sformatf("vec%0d", i));
    end

    // R6 R7: stop pulse and config changes during an automatic gate
    runAuto(2'd0, 1'b1, 5, 75, 10, 1'b1, "R6 R7 disturbed");

    // R6: stop while idle leaves result and done alone
    runManual(1'b0, 4, 4, "R6 setup");
    repeat (3) @(negedge clk);
    doStop();
    repeat (2) @(negedge clk);
    check(done == 1'b1, "R6 idle stop done kept", done, 1);
    check(result == 4, "R6 idle stop result kept", result, 4);

    // R3: edges while idle are not counted
    sendPulses(6);
    doStart(1'b1, 1'b0, 2'd0);
    repeat (10) @(negedge clk);
    doStop();
    check(result == 0, "R3 idle edges not counted", result, 0);

    // R8: restart during an open manual gate
    doStart(1'b1, 1'b0, 2'd0);
    sendPulses(5);
    doStart(1'b1, 1'b0, 2'd0);
    check(gateOpen == 1'b1 && done == 1'b0, "R8 gate reopened", {gateOpen, done}, 2);
    sendPulses(3);
    doStop();
    check(result == 3, "R8 restart discards count", result, 3);

    // R10: saturation on the narrow instance
    doStart(1'b1, 1'b1, 2'd0);
    sendTicks(70);
    doStop();
    check(result == 70 && overflow == 1'b0, "R10 wide no overflow", result, 70);
    check(resultN == 63, "R10 narrow saturates", resultN, 63);
    check(overflowN == 1'b1, "R10 narrow overflow flag", overflowN, 1);

    doStart(1'b1, 1'b1, 2'd0);
    sendTicks(63);
    doStop();
    check(resultN == 63 && overflowN == 1'b0, "R10 exact max no overflow", {overflowN, resultN}, 63);

    doStart(1'b1, 1'b1, 2'd0);
    sendTicks(64);
    doStop();
    check(resultN == 63 && overflowN == 1'b1, "R10 one past max", {overflowN, resultN}, 127);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule